// File: doc/BRIEF.md
# ISA Ready/Width Compatibility Logic

This block sits beside a slave I/O port on an ISA bus and produces the two open-drain pull-down enables that the port needs: one holds the channel-ready line low while the slave asks for more time, and one tells the host that the addressed port is 16 bits wide. A fast internal clock samples every bus signal, and each output is a register that reflects the inputs seen at the previous clock edge.

Some host chipsets sample these lines too early. Two compatibility modes handle this. The first delays the width indication until an I/O strobe is seen. The second pulls the ready line low as soon as the address latch strobe appears, before any I/O strobe. It holds it low until the first falling edge of the bus clock after that strobe ends, and it gives up at once if a memory strobe shows the cycle is not for this port. A sticky error flag records any cycle that the host ended while the slave still needed time. It is cleared by a write-one pulse.

Top module: `isa_rdy_width`

## Requirements
- R1: An address is in the window only when `aen` is 0 and `sa[9:5]` equals `BASE[9:5]`. Outside the window neither output enable is raised by the decode.
- R2: The mode code is 0 for normal, 1 for width-delay, 2 for early-ready, and 3 behaves as 0. In modes 0, 2 and 3, `io16_low` is 1 one clock after a word-port address is sampled. A word-port address is an in-window address with `sa[4:1]` equal to `WORD_OFS[4:1]`.
- R3: In mode 1, `io16_low` is 1 only one clock after a word-port address is sampled together with `iord_n` or `iowr_n` low. With no I/O strobe it stays 0.
- R4: In mode 2, an in-window address with `slave_busy` high and `bale` high raises `chrdy_low` one clock later, with no I/O strobe present. In modes 0 and 1, `bale` alone never raises it.
- R5: In mode 2, a sampled low on `mrd_n` or `mwr_n` drops the early `chrdy_low` one clock later, and no early pull-down can begin while a memory strobe is low.
- R6: Once `bale` is low, the early pull-down lasts until a falling edge of `isaclk` is sampled. It is 0 one clock after that edge, unless the strobe-qualified term holds it.
- R7: In every mode, `chrdy_low` is 1 one clock after an in-window address is sampled with `iord_n` or `iowr_n` low and `slave_busy` high. It is 0 when `slave_busy` is low and no early pull-down is active. Memory strobes never raise it.
- R8: `bus_err` becomes 1 one clock after an in-window I/O strobe ends while `slave_busy` is still high. It then holds until a `clr_err` pulse, and it is 0 one clock after that pulse.
- R9: If an error and `clr_err` arrive in the same cycle, the error wins and `bus_err` stays 1.
- R10: After reset, `chrdy_low`, `io16_low` and `bus_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa | input | 10 | Bus I/O address |
| aen | input | 1 | DMA address enable; high blocks the decode |
| bale | input | 1 | Address latch strobe, active high |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| mrd_n | input | 1 | Memory read strobe, active low |
| mwr_n | input | 1 | Memory write strobe, active low |
| isaclk | input | 1 | Sampled bus clock |
| slave_busy | input | 1 | Slave requests extra time |
| mode | input | 2 | Compatibility mode select |
| clr_err | input | 1 | Write-one pulse clearing the error flag |
| chrdy_low | output | 1 | Pull-down enable for the channel-ready line |
| io16_low | output | 1 | Pull-down enable for the 16-bit I/O line |
| bus_err | output | 1 | Sticky flag for a cycle ended while not ready |

## Verification
Two things can land in one cycle here: an error set and a software clear. The bench ends an in-window read while `slave_busy` is high and pulses `clr_err` in that same sample, then expects `bus_err` to read 1. It also releases the early pull-down in two competing ways. In one case a memory strobe arrives while `bale` is still high. In the other the `isaclk` falling edge arrives after `bale` has dropped. Each case is judged on the clock the release must appear.

// File: rtl/isa_rdy_width.sv
module isa_rdy_width #(
  parameter logic [9:0] BASE     = 10'h300,
  parameter logic [4:0] WORD_OFS = 5'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] sa,
  input  logic       aen,
  input  logic       bale,
  input  logic       iord_n,
  input  logic       iowr_n,
  input  logic       mrd_n,
  input  logic       mwr_n,
  input  logic       isaclk,
  input  logic       slave_busy,
  input  logic [1:0] mode,
  input  logic       clr_err,
  output logic       chrdy_low,
  output logic       io16_low,
  output logic       bus_err
);
  localparam logic [1:0] MODE_WDLY = 2'd1;
  localparam logic [1:0] MODE_ERDY = 2'd2;

  typedef enum logic [1:0] {E_IDLE, E_HOLD, E_TAIL} early_t;

  early_t est, est_nx;
  logic   clk_q, io_act_q;

  wire in_win   = !aen && (sa[9:5] == BASE[9:5]);
  wire is_word  = in_win && (sa[4:1] == WORD_OFS[4:1]);
  wire io_strb  = !iord_n || !iowr_n;
  wire mem_strb = !mrd_n || !mwr_n;
  wire clk_fall = clk_q && !isaclk;
  wire rdy_norm = in_win && io_strb && slave_busy;
  wire err_hit  = io_act_q && !io_strb && slave_busy;
  wire w16_nx   = (mode == MODE_WDLY) ? (is_word && io_strb) : is_word;

  always_comb begin
    est_nx = est;
    case (est)
      E_IDLE:
        if (mode == MODE_ERDY && bale && in_win && slave_busy && !mem_strb)
          est_nx = E_HOLD;
      E_HOLD:
        if (mem_strb)   est_nx = E_IDLE;
        else if (!bale) est_nx = clk_fall ? E_IDLE : E_TAIL;
      E_TAIL:
        if (mem_strb || clk_fall) est_nx = E_IDLE;
      default: est_nx = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est       <= E_IDLE;
      clk_q     <= 1'b0;
      io_act_q  <= 1'b0;
      chrdy_low <= 1'b0;
      io16_low  <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      est       <= est_nx;
      clk_q     <= isaclk;
      io_act_q  <= in_win && io_strb;
      chrdy_low <= rdy_norm || (est_nx != E_IDLE);
      io16_low  <= w16_nx;
      bus_err   <= err_hit || (bus_err && !clr_err);
    end
  end
endmodule

// File: rtl/isa_rdy_width_chk.sv
module isa_rdy_width_chk #(
  parameter logic [9:0] BASE     = 10'h300,
  parameter logic [4:0] WORD_OFS = 5'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] sa,
  input logic       aen,
  input logic       iord_n,
  input logic       iowr_n,
  input logic       mrd_n,
  input logic       mwr_n,
  input logic       slave_busy,
  input logic [1:0] mode,
  input logic       clr_err,
  input logic       chrdy_low,
  input logic       io16_low,
  input logic       bus_err
);
  wire win  = !aen && (sa[9:5] == BASE[9:5]);
  wire word = win && (sa[4:1] == WORD_OFS[4:1]);
  wire ios  = !iord_n || !iowr_n;
  wire mems = !mrd_n || !mwr_n;

  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> !io16_low);
  p_word_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word && mode != 2'd1) |=> io16_low);
  p_word_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word && mode == 2'd1 && !ios) |=> !io16_low);
  p_mem_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && mems && !ios) |=> !chrdy_low);
  p_strobe_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win && ios && slave_busy) |=> chrdy_low);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !clr_err) |=> bus_err);
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !slave_busy) |=> !bus_err);
endmodule

bind isa_rdy_width isa_rdy_width_chk #(.BASE(BASE), .WORD_OFS(WORD_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .iord_n(iord_n),
  .iowr_n(iowr_n), .mrd_n(mrd_n), .mwr_n(mwr_n), .slave_busy(slave_busy),
  .mode(mode), .clr_err(clr_err), .chrdy_low(chrdy_low),
  .io16_low(io16_low), .bus_err(bus_err)
);

// File: tb/isa_rdy_width_tb.sv
module isa_rdy_width_tb;
  localparam logic [9:0] BASE     = 10'h300;
  localparam logic [4:0] WORD_OFS = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] sa = '0;
  logic aen = 1'b0, bale = 1'b0, iord_n = 1'b1, iowr_n = 1'b1;
  logic mrd_n = 1'b1, mwr_n = 1'b1, isaclk = 1'b0, slave_busy = 1'b0;
  logic [1:0] mode = 2'd0;
  logic clr_err = 1'b0;
  logic chrdy_low, io16_low, bus_err;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  isa_rdy_width #(.BASE(BASE), .WORD_OFS(WORD_OFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .bale(bale),
    .iord_n(iord_n), .iowr_n(iowr_n), .mrd_n(mrd_n), .mwr_n(mwr_n),
    .isaclk(isaclk), .slave_busy(slave_busy), .mode(mode), .clr_err(clr_err),
    .chrdy_low(chrdy_low), .io16_low(io16_low), .bus_err(bus_err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle();
    bale = 0; iord_n = 1; iowr_n = 1; mrd_n = 1; mwr_n = 1;
    slave_busy = 0; clr_err = 0; aen = 0;
    step();
  endtask

  function automatic logic f_win(input int a, input int e);
    return (e == 0) && ((a >> 5) == (int'(BASE) >> 5));
  endfunction

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R10 chrdy", chrdy_low, 1'b0);
    chk("R10 io16", io16_low, 1'b0);
    chk("R10 err", bus_err, 1'b0);
    rst_n = 1'b1;
    step();

    // R1 R2 R3: width indication across all addresses, modes and strobes
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 1024; a++)
        for (int e = 0; e < 2; e++)
          for (int s = 0; s < 2; s++) begin
            logic w, exp;
            mode = 2'(m); sa = 10'(a); aen = 1'(e); iord_n = !(s == 1);
            w = f_win(a, e) && (((a & 31) >> 1) == (int'(WORD_OFS) >> 1));
            exp = (m == 1) ? (w && s == 1) : w;
            step();
            if (!f_win(a, e)) chk("R1 io16", io16_low, exp);
            else if (m == 1)  chk("R3 io16", io16_low, exp);
            else              chk("R2 io16", io16_low, exp);
          end
    idle();

    // R7: strobe-qualified ready over strobe kinds, busy, window
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 5; k++)
        for (int b = 0; b < 2; b++)
          for (int p = 0; p < 3; p++) begin
            logic exp;
            mode = 2'(m); slave_busy = 1'(b);
            sa = (p == 1) ? 10'h340 : (BASE + 10'd3);
            aen = (p == 2);
            iord_n = (k != 1); iowr_n = (k != 2); mrd_n = (k != 3); mwr_n = (k != 4);
            exp = (p == 0) && (k == 1 || k == 2) && (b == 1);
            step();
            chk("R7 chrdy", chrdy_low, exp);
            iord_n = 1; iowr_n = 1; mrd_n = 1; mwr_n = 1;
            step();
            idle();
          end
    clr_err = 1; step(); clr_err = 0;

    // R4 R6: early ready in mode 2, released on isaclk fall
    mode = 2'd2; sa = BASE + 10'd8; slave_busy = 1; isaclk = 0; bale = 1;
    step();
    chk("R4 early on bale", chrdy_low, 1'b1);
    bale = 0; step();
    chk("R6 held after bale", chrdy_low, 1'b1);
    isaclk = 1; step();
    chk("R6 held isaclk high", chrdy_low, 1'b1);
    isaclk = 0; step();
    chk("R6 release on fall", chrdy_low, 1'b0);
    idle();

    // R4: bale alone in modes 0 and 1
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m); sa = BASE + 10'd8; slave_busy = 1; bale = 1;
      step();
      chk("R4 no early mode0/1", chrdy_low, 1'b0);
      idle();
    end

    // R5: memory strobe drops the early pull-down and blocks a new one
    mode = 2'd2; sa = BASE + 10'd8; slave_busy = 1; bale = 1;
    step();
    chk("R4 early again", chrdy_low, 1'b1);
    mrd_n = 0; step();
    chk("R5 mrd release", chrdy_low, 1'b0);
    step();
    chk("R5 stays released", chrdy_low, 1'b0);
    mrd_n = 1; bale = 0; step();
    idle();
    mode = 2'd2; sa = BASE + 10'd8; slave_busy = 1; bale = 1; mwr_n = 0;
    step();
    chk("R5 mwr blocks start", chrdy_low, 1'b0);
    idle();

    // R8: error set, sticky, cleared
    mode = 2'd0; sa = BASE + 10'd2; slave_busy = 1; iord_n = 0;
    step();
    chk("R7 busy read", chrdy_low, 1'b1);
    iord_n = 1; step();
    chk("R8 err set", bus_err, 1'b1);
    slave_busy = 0; step(); step();
    chk("R8 err sticky", bus_err, 1'b1);
    chk("R7 released", chrdy_low, 1'b0);
    clr_err = 1; step(); clr_err = 0;
    chk("R8 err cleared", bus_err, 1'b0);
    iowr_n = 0; step(); iowr_n = 1; step();
    chk("R8 no err when ready", bus_err, 1'b0);

    // R9: set and clear in the same cycle
    slave_busy = 1; iord_n = 0; step();
    iord_n = 1; clr_err = 1; step();
    clr_err = 0;
    chk("R9 set beats clear", bus_err, 1'b1);
    idle();
    clr_err = 1; step(); clr_err = 0;
    chk("R8 final clear", bus_err, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule